// File: doc/BRIEF.md
# Memory Access Error Capture

This block sits beside a memory controller and watches the request/accept handshake on the port that connects the controller to the on-chip interconnect. A request is open from the first cycle its valid is high until the controller raises accept. The block flags three kinds of faulty transfer:

- a request that begins while the memory is in deep power-down;
- a request that begins with a failed permission check from the initiator;
- a request that waits longer than a programmable number of cycles without being accepted.

The first fault is recorded for software. The record holds the faulting address, the initiator ID and a 2-bit kind code. An error-valid flag reports that the record is loaded. Any further fault that arrives while the record is loaded leaves the record unchanged and sets a sticky overflow bit. Software drops the record with a one-cycle clear pulse.

Top module: `mem_err_capture`

## Requirements
- R1: After reset, err_valid, err_overflow, err_kind, err_addr and err_initiator are all zero.
- R2: A request whose first cycle has mem_deep_pd high is a fault of kind 2'b10. The cycle after, err_valid is 1 and err_addr/err_initiator hold that request's address and ID.
- R3: A request whose first cycle has mem_deep_pd low and perm_ok low is a fault of kind 2'b11, captured the same way as in R2.
- R4: With tmo_limit = L > 0, the L-th cycle of a request in which req_valid is high and req_accept is low is a fault of kind 2'b01. With tmo_limit = 0 the timeout never fires.
- R5: A request accepted before its L-th unaccepted cycle raises no timeout. This includes a request accepted in the cycle after L-1 unaccepted cycles.
- R6: The wait count restarts for every new request. A new request starts on the first cycle req_valid is high after a cycle with no open request, or after a cycle with an accept.
- R7: While err_valid is 1, later faults leave err_kind, err_addr and err_initiator unchanged and set err_overflow to 1.
- R8: A cycle with err_clear high and no fault clears err_valid and err_overflow. When a fault coincides with err_clear, that fault is captured fresh and err_overflow is 0.
- R9: When two faults occur in one cycle, the start fault (2'b10 or 2'b11) wins over the timeout (2'b01), and err_overflow is set.
- R10: Power state and permission are judged only in a request's first cycle. Changes to them while the request waits raise no fault.
- R11: A single request raises at most one timeout, however long it stays unaccepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid from the interconnect |
| req_accept | input | 1 | Accept given by the memory controller |
| req_addr | input | AW (32) | Request address, held while the request is open |
| req_initiator | input | IDW (8) | Initiator ID of the request |
| perm_ok | input | 1 | Permission check result, 1 = allowed |
| mem_deep_pd | input | 1 | Memory is in deep power-down |
| tmo_limit | input | CW (16) | Accept window in cycles, 0 disables the timeout |
| err_clear | input | 1 | Software clear pulse for the error record |
| err_valid | output | 1 | Error record loaded |
| err_overflow | output | 1 | Further faults occurred while the record was loaded |
| err_kind | output | 2 | 01 timeout, 10 power-down access, 11 illegal initiator |
| err_addr | output | AW (32) | Address of the recorded fault |
| err_initiator | output | IDW (8) | Initiator ID of the recorded fault |

## Verification
The bench aims at the accept edge of the window. An accept in the cycle after L-1 waits must stay silent, while an off-by-one counter would flag it or would let the L-th wait pass. It runs back-to-back requests to show that the counter restarts at each request, and holds one request open well past the limit to show the timeout fires only once; a design that re-armed the counter would raise overflow there. It also covers faults that coincide with a clear (a design that let the clear win would lose the fault), the same-cycle start fault plus timeout at a limit of one, and changes to power state and permission in mid-wait that a level-sensitive check would wrongly report.

// File: rtl/mec_pkg.sv
package mec_pkg;

  typedef enum logic [1:0] {
    KIND_NONE    = 2'b00,
    KIND_TIMEOUT = 2'b01,
    KIND_PWRDN   = 2'b10,
    KIND_ILLEGAL = 2'b11
  } err_kind_e;

  // Highest-priority kind among the faults seen in one cycle.
  function automatic err_kind_e pick_kind(input logic pd, input logic ill, input logic tmo);
    if (pd)       return KIND_PWRDN;
    else if (ill) return KIND_ILLEGAL;
    else if (tmo) return KIND_TIMEOUT;
    else          return KIND_NONE;
  endfunction

  // Number of faults raised in one cycle.
  function automatic logic [1:0] fault_count(input logic pd, input logic ill, input logic tmo);
    return {1'b0, pd} + {1'b0, ill} + {1'b0, tmo};
  endfunction

endpackage

// File: rtl/mec_req_track.sv
module mec_req_track (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_accept,
  output logic new_req,
  output logic open_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= req_valid && !req_accept;
  end

  assign new_req = req_valid && !open_q;

  // R6: after an accept, the next valid cycle starts a fresh request
  p_accept_restarts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_accept) |=> (!req_valid || new_req));

endmodule

// File: rtl/mec_wait_timer.sv
module mec_wait_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_accept,
  input  logic          new_req,
  input  logic [CW-1:0] limit,
  output logic          tmo_evt
);

  logic [CW-1:0] count_q;
  logic [CW-1:0] base;
  logic          waiting;

  // True when one more unaccepted cycle makes the wait reach the limit.
  function automatic logic reaches_limit(input logic [CW-1:0] done, input logic [CW-1:0] lim);
    return (lim != '0) && ({1'b0, done} + 1'b1 == {1'b0, lim});
  endfunction

  assign waiting = req_valid && !req_accept;
  assign base    = new_req ? '0 : count_q;
  assign tmo_evt = waiting && reaches_limit(base, limit);

  always_ff @(posedge clk) begin
    if (!rst_n)                         count_q <= '0;
    else if (!waiting)                  count_q <= '0;
    else if ({1'b0, base} < {1'b0, limit}) count_q <= base + 1'b1;
    else                                count_q <= base;
  end

  // R11: a timeout is followed by silence unless a new request starts
  p_timeout_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> (new_req || !tmo_evt));

endmodule

// File: rtl/mec_err_latch.sv
module mec_err_latch
  import mec_pkg::*;
#(
  parameter int AW  = 32,
  parameter int IDW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           evt_pd,
  input  logic           evt_ill,
  input  logic           evt_tmo,
  input  logic [AW-1:0]  addr,
  input  logic [IDW-1:0] initiator,
  input  logic           sw_clear,
  output logic           err_valid,
  output logic           err_overflow,
  output err_kind_e      err_kind,
  output logic [AW-1:0]  err_addr,
  output logic [IDW-1:0] err_initiator
);

  logic any_evt;
  logic multi_evt;

  assign any_evt   = evt_pd || evt_ill || evt_tmo;
  assign multi_evt = fault_count(evt_pd, evt_ill, evt_tmo) > 2'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_valid     <= 1'b0;
      err_overflow  <= 1'b0;
      err_kind      <= KIND_NONE;
      err_addr      <= '0;
      err_initiator <= '0;
    end else if (any_evt) begin
      if (!err_valid || sw_clear) begin
        err_valid     <= 1'b1;
        err_overflow  <= multi_evt;
        err_kind      <= pick_kind(evt_pd, evt_ill, evt_tmo);
        err_addr      <= addr;
        err_initiator <= initiator;
      end else begin
        err_overflow  <= 1'b1;
      end
    end else if (sw_clear) begin
      err_valid     <= 1'b0;
      err_overflow  <= 1'b0;
      err_kind      <= KIND_NONE;
      err_addr      <= '0;
      err_initiator <= '0;
    end
  end

  // R7: a loaded record stays put until software clears it
  p_record_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && !sw_clear) |=> (err_valid && $stable(err_addr) && $stable(err_kind)
                                  && $stable(err_initiator)));

  // R7: any fault leaves the record loaded
  p_fault_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt |=> err_valid);

  // R8: a clear with no fault empties the record
  p_clear_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clear && !any_evt) |=> (!err_valid && !err_overflow));

endmodule

// File: rtl/mem_err_capture.sv
module mem_err_capture
  import mec_pkg::*;
#(
  parameter int AW  = 32,
  parameter int IDW = 8,
  parameter int CW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic           req_accept,
  input  logic [AW-1:0]  req_addr,
  input  logic [IDW-1:0] req_initiator,
  input  logic           perm_ok,
  input  logic           mem_deep_pd,
  input  logic [CW-1:0]  tmo_limit,
  input  logic           err_clear,
  output logic           err_valid,
  output logic           err_overflow,
  output logic [1:0]     err_kind,
  output logic [AW-1:0]  err_addr,
  output logic [IDW-1:0] err_initiator
);

  logic      new_req;
  logic      open_q;
  logic      evt_pd;
  logic      evt_ill;
  logic      evt_tmo;
  err_kind_e kind_q;

  mec_req_track u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_accept (req_accept),
    .new_req    (new_req),
    .open_q     (open_q)
  );

  // Start checks are judged once, in the first cycle of a request.
  assign evt_pd  = new_req && mem_deep_pd;
  assign evt_ill = new_req && !mem_deep_pd && !perm_ok;

  mec_wait_timer #(.CW(CW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_accept (req_accept),
    .new_req    (new_req),
    .limit      (tmo_limit),
    .tmo_evt    (evt_tmo)
  );

  mec_err_latch #(.AW(AW), .IDW(IDW)) u_latch (
    .clk           (clk),
    .rst_n         (rst_n),
    .evt_pd        (evt_pd),
    .evt_ill       (evt_ill),
    .evt_tmo       (evt_tmo),
    .addr          (req_addr),
    .initiator     (req_initiator),
    .sw_clear      (err_clear),
    .err_valid     (err_valid),
    .err_overflow  (err_overflow),
    .err_kind      (kind_q),
    .err_addr      (err_addr),
    .err_initiator (err_initiator)
  );

  assign err_kind = kind_q;

  // R10: while a request is still waiting, no start fault is raised
  p_no_midwait_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && req_valid) |-> !(evt_pd || evt_ill));

endmodule

// File: tb/mem_err_capture_tb_top.sv
module mem_err_capture_tb_top;
  localparam int AW = 32;
  localparam int IDW = 8;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_accept = 1'b0, perm_ok = 1'b1, mem_deep_pd = 1'b0, err_clear = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [IDW-1:0] req_initiator = '0;
  logic [CW-1:0] tmo_limit = '0;
  logic err_valid, err_overflow;
  logic [1:0] err_kind;
  logic [AW-1:0] err_addr;
  logic [IDW-1:0] err_initiator;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mem_err_capture #(.AW(AW), .IDW(IDW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_accept(req_accept),
    .req_addr(req_addr), .req_initiator(req_initiator), .perm_ok(perm_ok),
    .mem_deep_pd(mem_deep_pd), .tmo_limit(tmo_limit), .err_clear(err_clear),
    .err_valid(err_valid), .err_overflow(err_overflow), .err_kind(err_kind),
    .err_addr(err_addr), .err_initiator(err_initiator));

  // Behavioural reference model
  bit m_open; int m_waited; bit m_valid, m_ovf; int m_kind; longint m_addr; int m_ini;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_open = 0; m_waited = 0; m_valid = 0; m_ovf = 0; m_kind = 0; m_addr = 0; m_ini = 0;
    end else begin
      bit first, pd, il, tm;
      int w, nf, k;
      first = req_valid && !m_open;
      w = first ? 0 : m_waited;
      pd = first && mem_deep_pd;
      il = first && !mem_deep_pd && !perm_ok;
      tm = req_valid && !req_accept && (tmo_limit != 0) && (w + 1 == int'(tmo_limit));
      nf = int'(pd) + int'(il) + int'(tm);
      k = pd ? 2 : (il ? 3 : (tm ? 1 : 0));
      if (nf > 0) begin
        if (!m_valid || err_clear) begin
          m_valid = 1; m_ovf = (nf > 1); m_kind = k; m_addr = req_addr; m_ini = req_initiator;
        end else m_ovf = 1;
      end else if (err_clear) begin
        m_valid = 0; m_ovf = 0; m_kind = 0; m_addr = 0; m_ini = 0;
      end
      if (req_valid && !req_accept) m_waited = (w < int'(tmo_limit)) ? w + 1 : w;
      else m_waited = 0;
      m_open = req_valid && !req_accept;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (err_valid !== m_valid || err_overflow !== m_ovf || int'(err_kind) != m_kind ||
          longint'(err_addr) != m_addr || int'(err_initiator) != m_ini) begin
        failures++;
        $display("FAIL MODEL: got v=%0b o=%0b k=%0d a=%h i=%h exp v=%0b o=%0b k=%0d a=%h i=%h",
                 err_valid, err_overflow, err_kind, err_addr, err_initiator,
                 m_valid, m_ovf, m_kind, m_addr, m_ini);
      end
    end
  end

  task automatic chk(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // Apply inputs at a negedge, let one posedge consume them, return at the next negedge.
  task automatic cyc(input bit v, input bit acc, input logic [AW-1:0] a, input logic [IDW-1:0] id,
                     input bit pd, input bit ok, input bit clr);
    req_valid = v; req_accept = acc; req_addr = a; req_initiator = id;
    mem_deep_pd = pd; perm_ok = ok; err_clear = clr;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, '0, '0, 0, 1, 0);
  endtask

  task automatic do_clear();
    cyc(0, 0, '0, '0, 0, 1, 1);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL WATCHDOG: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid", err_valid, 0); chk("R1 kind", err_kind, 0);
    chk("R1 addr", err_addr, 0); chk("R1 ovf", err_overflow, 0);

    tmo_limit = 4;
    // R5: accepted after 3 unaccepted cycles
    for (int i = 0; i < 3; i++) cyc(1, 0, 32'h100, 8'h1, 0, 1, 0);
    cyc(1, 1, 32'h100, 8'h1, 0, 1, 0);
    idle(1);
    chk("R5 no timeout at edge", err_valid, 0);

    // R6: back-to-back requests each within window
    for (int i = 0; i < 3; i++) cyc(1, 0, 32'h200, 8'h2, 0, 1, 0);
    cyc(1, 1, 32'h200, 8'h2, 0, 1, 0);
    for (int i = 0; i < 3; i++) cyc(1, 0, 32'h300, 8'h3, 0, 1, 0);
    cyc(1, 1, 32'h300, 8'h3, 0, 1, 0);
    idle(1);
    chk("R6 count restarts", err_valid, 0);

    // R4 / R11: timeout on the 4th unaccepted cycle, only once
    for (int i = 0; i < 3; i++) cyc(1, 0, 32'hABC0, 8'h44, 0, 1, 0);
    chk("R4 not yet", err_valid, 0);
    cyc(1, 0, 32'hABC0, 8'h44, 0, 1, 0);
    chk("R4 valid", err_valid, 1); chk("R4 kind", err_kind, 1);
    chk("R4 addr", err_addr, 32'hABC0); chk("R4 initiator", err_initiator, 8'h44);
    for (int i = 0; i < 8; i++) cyc(1, 0, 32'hABC0, 8'h44, 0, 1, 0);
    cyc(1, 1, 32'hABC0, 8'h44, 0, 1, 0);
    chk("R11 single timeout", err_overflow, 0);
    do_clear();
    chk("R8 clear valid", err_valid, 0); chk("R8 clear ovf", err_overflow, 0);

    // R2 then R7
    cyc(1, 1, 32'h5000, 8'h7, 1, 1, 0);
    chk("R2 valid", err_valid, 1); chk("R2 kind", err_kind, 2); chk("R2 addr", err_addr, 32'h5000);
    cyc(1, 1, 32'h6000, 8'h9, 0, 0, 0);
    chk("R7 ovf", err_overflow, 1); chk("R7 kind kept", err_kind, 2); chk("R7 addr kept", err_addr, 32'h5000);
    do_clear();
    chk("R8 clear after ovf", err_overflow, 0);

    // R3
    cyc(1, 1, 32'h7000, 8'h11, 0, 0, 0);
    chk("R3 kind", err_kind, 3); chk("R3 addr", err_addr, 32'h7000); chk("R3 ovf", err_overflow, 0);

    // R8: fault coinciding with clear is captured fresh
    cyc(1, 1, 32'h7100, 8'h12, 1, 1, 1);
    chk("R8 fresh valid", err_valid, 1); chk("R8 fresh kind", err_kind, 2);
    chk("R8 fresh addr", err_addr, 32'h7100); chk("R8 fresh ovf", err_overflow, 0);
    do_clear();

    // R9: limit 1, power-down start plus timeout in one cycle
    tmo_limit = 1;
    cyc(1, 0, 32'h8000, 8'h21, 1, 1, 0);
    chk("R9 kind", err_kind, 2); chk("R9 ovf", err_overflow, 1);
    cyc(1, 1, 32'h8000, 8'h21, 1, 1, 0);
    do_clear();

    // R10: power and permission change mid-wait
    tmo_limit = 6;
    cyc(1, 0, 32'h9000, 8'h31, 0, 1, 0);
    for (int i = 0; i < 3; i++) cyc(1, 0, 32'h9000, 8'h31, 1, 0, 0);
    cyc(1, 1, 32'h9000, 8'h31, 1, 0, 0);
    idle(1);
    chk("R10 no mid-wait fault", err_valid, 0);

    // R4: limit 0 disables
    tmo_limit = 0;
    for (int i = 0; i < 20; i++) cyc(1, 0, 32'hA000, 8'h41, 0, 1, 0);
    cyc(1, 1, 32'hA000, 8'h41, 0, 1, 0);
    chk("R4 disabled", err_valid, 0);

    // Mixed traffic against the model
    tmo_limit = 3;
    for (int i = 0; i < 400; i++) begin
      bit v, acc, pd, ok, clr;
      v = ($urandom_range(0, 3) != 0);
      acc = ($urandom_range(0, 2) == 0);
      pd = ($urandom_range(0, 7) == 0);
      ok = ($urandom_range(0, 5) != 0);
      clr = ($urandom_range(0, 9) == 0);
      cyc(v, acc, $urandom(), 8'($urandom()), pd, ok, clr);
    end
    idle(2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule